// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit load/store processor core. It offers sixteen logical registers through two combinational read ports and one write port, each addressed by a 4-bit index. A 5-bit operating-mode input decides which physical copy a logical index reaches. The fast-interrupt mode owns a deep private bank covering indices 8 to 14. Four other exception modes each own only a private stack pointer (index 13) and link register (index 14). User mode, system mode and any unrecognised mode value share one base bank. Index 15 is the single program counter, and it is treated as an ordinary write target.

Beside the general registers, the block holds the current status word. It also holds one saved status word for each of the five exception modes, and only the current mode's copy is reachable. A separate user-bank port, with one read and one write, always addresses the user-mode copies. Privileged software uses it to save and restore the user context without changing mode. Every write lands on the next rising clock edge. Reads are combinational and show the stored value.

Top module: `banked_regfile`

## Requirements
- R1: An active-low reset clears every general register, the program counter, the current status word and all saved status words to zero.
- R2: A write lands on the next rising edge. A read of the same physical register in the write cycle returns the old value, and a read in the cycle after returns the new value.
- R3: Indices 0 to 7 reach the same physical registers in every mode.
- R4: In fast-interrupt mode (mode 5'b10001), indices 8 to 14 reach private copies that are distinct from the user copies.
- R5: In IRQ (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes, indices 13 and 14 reach copies private to each mode. Indices 8 to 12 reach the user copies.
- R6: System mode (5'b11111) and every mode value not listed in R4, R5 or user (5'b10000) reach exactly the user-mode registers.
- R7: Index 15 is one program counter shared by all modes. Bits 1:0 of any value read from it are zero.
- R8: Each of the five exception modes has its own saved status word. A saved-status write in one of these modes changes only that mode's copy.
- R9: In user, system or unrecognised modes, the saved-status output shows the current status word, and a saved-status write has no effect.
- R10: The user-bank port reads and writes the user-mode copy of indices 0 to 14, and the program counter at index 15, whatever the current mode.
- R11: When the main write port and the user-bank write port target the same physical register in one cycle, the main port's data is stored. When they target different physical registers, both are stored.
- R12: A current-status write lands on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Main write enable |
| wr_idx_i | input | 4 | Main write logical index |
| wr_data_i | input | 32 | Main write data |
| usr_rd_idx_i | input | 4 | User-bank read index |
| usr_rd_data_o | output | 32 | User-bank read data |
| usr_wr_en_i | input | 1 | User-bank write enable |
| usr_wr_idx_i | input | 4 | User-bank write index |
| usr_wr_data_i | input | 32 | User-bank write data |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_wr_en_i | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode |

## Verification
Every read output is combinational, so a read result is due in the same cycle that its index and mode are applied. A write result is due exactly one rising edge after the cycle that holds the enable. The driver applies each stimulus just after a falling edge and queues the outputs expected for that cycle. The monitor compares them two nanoseconds later, before the next rising edge. Old-value checks are therefore queued in the write cycle itself, and new-value checks are queued in the cycle after.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int DATA_W      = 32;
    localparam int LOG_W       = 4;
    localparam int NUM_LOG     = 1 << LOG_W;
    localparam int PC_IDX      = NUM_LOG - 1;
    localparam int FIQ_FIRST   = 8;
    localparam int BANK_FIRST  = 13;
    localparam int FIQ_PRIV    = PC_IDX - FIQ_FIRST;
    localparam int SMALL_MODES = 4;
    localparam int SMALL_PRIV  = PC_IDX - BANK_FIRST;
    localparam int NUM_PHYS    = NUM_LOG + FIQ_PRIV + SMALL_MODES * SMALL_PRIV;
    localparam int PHYS_W      = $clog2(NUM_PHYS);
    localparam int NUM_SAVED   = SMALL_MODES + 1;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    function automatic bank_e decode_mode(input logic [4:0] m);
        case (m)
            5'b10001: decode_mode = BK_FIQ;
            5'b10010: decode_mode = BK_IRQ;
            5'b10011: decode_mode = BK_SVC;
            5'b10111: decode_mode = BK_ABT;
            5'b11011: decode_mode = BK_UND;
            default:  decode_mode = BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import banked_rf_pkg::*;
#(
    parameter int IDX_W = LOG_W,
    parameter int OUT_W = PHYS_W
) (
    input  bank_e            bank_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [OUT_W-1:0] phys_o
);

    localparam int SMALL_BASE = NUM_LOG + FIQ_PRIV;

    always_comb begin
        int p;
        int li;
        li = int'(idx_i);
        p  = li;
        if (li != PC_IDX) begin
            if (bank_i == BK_FIQ && li >= FIQ_FIRST) begin
                p = NUM_LOG + li - FIQ_FIRST;
            end else if (bank_i inside {BK_IRQ, BK_SVC, BK_ABT, BK_UND} && li >= BANK_FIRST) begin
                p = SMALL_BASE + (int'(bank_i) - int'(BK_IRQ)) * SMALL_PRIV + li - BANK_FIRST;
            end
        end
        phys_o = OUT_W'(p);
    end

endmodule

// File: rtl/rf_saved_status.sv
module rf_saved_status
    import banked_rf_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int SLOTS = NUM_SAVED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_e            bank_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] cpsr_i,
    output logic [WIDTH-1:0] rd_o
);

    typedef struct packed {
        logic [SLOTS-1:0][WIDTH-1:0] slot;
    } sst_t;

    sst_t st_d, st_q;
    logic started_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && bank_i != BK_USR) begin
            st_d.slot[int'(bank_i) - 1] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            started_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            started_q <= 1'b1;
        end
    end

    always_comb begin
        if (bank_i == BK_USR) rd_o = cpsr_i;
        else                  rd_o = st_q.slot[int'(bank_i) - 1];
    end

    // R8
    spsr_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(wr_en_i) && $past(bank_i) != BK_USR && bank_i == $past(bank_i))
        |-> rd_o == $past(wr_data_i));

    // R8
    spsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !$past(wr_en_i) && $past(bank_i) != BK_USR && bank_i == $past(bank_i))
        |-> $stable(rd_o));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [LOG_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [LOG_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [LOG_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LOG_W-1:0]  usr_rd_idx_i,
    output logic [DATA_W-1:0] usr_rd_data_o,
    input  logic              usr_wr_en_i,
    input  logic [LOG_W-1:0]  usr_wr_idx_i,
    input  logic [DATA_W-1:0] usr_wr_data_i,
    input  logic              cpsr_wr_en_i,
    input  logic [DATA_W-1:0] cpsr_wr_data_i,
    output logic [DATA_W-1:0] cpsr_o,
    input  logic              spsr_wr_en_i,
    input  logic [DATA_W-1:0] spsr_wr_data_i,
    output logic [DATA_W-1:0] spsr_o
);

    localparam int NUM_PORTS = 5;
    localparam int P_RDA = 0;
    localparam int P_RDB = 1;
    localparam int P_WR  = 2;
    localparam int P_URD = 3;
    localparam int P_UWR = 4;

    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]               cpsr;
    } rf_t;

    rf_t   rf_d, rf_q;
    bank_e cur_bank;
    logic  started_q;

    bank_e            map_bank [NUM_PORTS];
    logic [LOG_W-1:0] map_idx  [NUM_PORTS];
    logic [PHYS_W-1:0] map_phys [NUM_PORTS];

    assign cur_bank = decode_mode(mode_i);

    always_comb begin
        map_bank[P_RDA] = cur_bank;  map_idx[P_RDA] = rd_a_idx_i;
        map_bank[P_RDB] = cur_bank;  map_idx[P_RDB] = rd_b_idx_i;
        map_bank[P_WR]  = cur_bank;  map_idx[P_WR]  = wr_idx_i;
        map_bank[P_URD] = BK_USR;    map_idx[P_URD] = usr_rd_idx_i;
        map_bank[P_UWR] = BK_USR;    map_idx[P_UWR] = usr_wr_idx_i;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_map
        rf_bank_map #(
            .IDX_W (LOG_W),
            .OUT_W (PHYS_W)
        ) i_map (
            .bank_i (map_bank[g]),
            .idx_i  (map_idx[g]),
            .phys_o (map_phys[g])
        );
    end

    function automatic logic [DATA_W-1:0] pc_fix(input logic [PHYS_W-1:0] p,
                                                 input logic [DATA_W-1:0] v);
        pc_fix = (int'(p) == PC_IDX) ? {v[DATA_W-1:2], 2'b00} : v;
    endfunction

    always_comb begin
        rf_d = rf_q;
        if (usr_wr_en_i) begin
            rf_d.gpr[map_phys[P_UWR]] = pc_fix(map_phys[P_UWR], usr_wr_data_i);
        end
        if (wr_en_i) begin
            rf_d.gpr[map_phys[P_WR]] = pc_fix(map_phys[P_WR], wr_data_i);
        end
        if (cpsr_wr_en_i) begin
            rf_d.cpsr = cpsr_wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q      <= '0;
            started_q <= 1'b0;
        end else begin
            rf_q      <= rf_d;
            started_q <= 1'b1;
        end
    end

    assign rd_a_data_o   = rf_q.gpr[map_phys[P_RDA]];
    assign rd_b_data_o   = rf_q.gpr[map_phys[P_RDB]];
    assign usr_rd_data_o = rf_q.gpr[map_phys[P_URD]];
    assign cpsr_o        = rf_q.cpsr;

    rf_saved_status #(
        .WIDTH (DATA_W),
        .SLOTS (NUM_SAVED)
    ) i_saved (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_i    (cur_bank),
        .wr_en_i   (spsr_wr_en_i),
        .wr_data_i (spsr_wr_data_i),
        .cpsr_i    (rf_q.cpsr),
        .rd_o      (spsr_o)
    );

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(wr_en_i) && int'($past(wr_idx_i)) != PC_IDX
         && mode_i == $past(mode_i) && rd_a_idx_i == $past(wr_idx_i))
        |-> rd_a_data_o == $past(wr_data_i));

    // R3
    low_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_a_idx_i) < FIQ_FIRST && usr_rd_idx_i == rd_a_idx_i)
        |-> rd_a_data_o == usr_rd_data_o);

    // R7
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_b_idx_i) == PC_IDX) |-> rd_b_data_o[1:0] == 2'b00);

    // R7
    pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_a_idx_i) == PC_IDX && int'(usr_rd_idx_i) == PC_IDX)
        |-> rd_a_data_o == usr_rd_data_o);

    // R11
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(wr_en_i) && $past(usr_wr_en_i)
         && decode_mode($past(mode_i)) == BK_USR && $past(wr_idx_i) == $past(usr_wr_idx_i)
         && int'($past(wr_idx_i)) != PC_IDX && mode_i == $past(mode_i)
         && rd_a_idx_i == $past(wr_idx_i))
        |-> rd_a_data_o == $past(wr_data_i));

    // R12
    cpsr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(cpsr_wr_en_i)) |-> cpsr_o == $past(cpsr_wr_data_i));

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {O_A, O_B, O_U, O_CPSR, O_SPSR} out_e;
    typedef struct {
        out_e        which;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = M_USR;
    logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
    logic [3:0]  usr_rd_idx_i = '0, usr_wr_idx_i = '0;
    logic        wr_en_i = 1'b0, usr_wr_en_i = 1'b0, cpsr_wr_en_i = 1'b0, spsr_wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0, usr_wr_data_i = '0, cpsr_wr_data_i = '0, spsr_wr_data_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o, usr_rd_data_o, cpsr_o, spsr_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .rd_a_idx_i     (rd_a_idx_i),
        .rd_a_data_o    (rd_a_data_o),
        .rd_b_idx_i     (rd_b_idx_i),
        .rd_b_data_o    (rd_b_data_o),
        .wr_en_i        (wr_en_i),
        .wr_idx_i       (wr_idx_i),
        .wr_data_i      (wr_data_i),
        .usr_rd_idx_i   (usr_rd_idx_i),
        .usr_rd_data_o  (usr_rd_data_o),
        .usr_wr_en_i    (usr_wr_en_i),
        .usr_wr_idx_i   (usr_wr_idx_i),
        .usr_wr_data_i  (usr_wr_data_i),
        .cpsr_wr_en_i   (cpsr_wr_en_i),
        .cpsr_wr_data_i (cpsr_wr_data_i),
        .cpsr_o         (cpsr_o),
        .spsr_wr_en_i   (spsr_wr_en_i),
        .spsr_wr_data_i (spsr_wr_data_i),
        .spsr_o         (spsr_o)
    );

    // driver side: queue an expected output for the current cycle
    task automatic expect_out(input out_e w, input logic [31:0] e, input string tag);
        item_t it;
        it.which = w;
        it.exp   = e;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // advance to the next falling edge and drop all write strobes
    task automatic cyc();
        @(negedge clk);
        wr_en_i      = 1'b0;
        usr_wr_en_i  = 1'b0;
        cpsr_wr_en_i = 1'b0;
        spsr_wr_en_i = 1'b0;
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        wr_en_i = 1'b1; wr_idx_i = i; wr_data_i = d;
    endtask

    task automatic uwr(input logic [3:0] i, input logic [31:0] d);
        usr_wr_en_i = 1'b1; usr_wr_idx_i = i; usr_wr_data_i = d;
    endtask

    // monitor: compare queued items shortly after the falling edge
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.which)
                O_A:     act = rd_a_data_o;
                O_B:     act = rd_b_data_o;
                O_U:     act = usr_rd_data_o;
                O_CPSR:  act = cpsr_o;
                default: act = spsr_o;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s port=%s actual=%h expected=%h", it.tag, it.which.name(), act, it.exp);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        mode_i = M_USR; rd_a_idx_i = 0; rd_b_idx_i = 15;
        expect_out(O_A, 32'h0, "R1"); expect_out(O_B, 32'h0, "R1");
        expect_out(O_CPSR, 32'h0, "R1");
        cyc();
        mode_i = M_FIQ; rd_a_idx_i = 8;
        expect_out(O_A, 32'h0, "R1"); expect_out(O_SPSR, 32'h0, "R1");
        cyc();
        // R2 old value in write cycle
        mode_i = M_USR; wr(8, 32'hA1A1_0008); uwr(13, 32'hA1A1_000D);
        rd_a_idx_i = 8; expect_out(O_A, 32'h0, "R2");
        cyc();
        wr(0, 32'hA1A1_0000);
        expect_out(O_A, 32'hA1A1_0008, "R2");
        usr_rd_idx_i = 13; expect_out(O_U, 32'hA1A1_000D, "R10");
        cyc();
        wr(15, 32'h0000_1003);
        rd_a_idx_i = 0; expect_out(O_A, 32'hA1A1_0000, "R2");
        cyc();
        // R7 PC alignment, R3 low shared, R4 FIQ bank
        mode_i = M_FIQ; rd_a_idx_i = 15; rd_b_idx_i = 0; usr_rd_idx_i = 8;
        expect_out(O_A, 32'h0000_1000, "R7");
        expect_out(O_B, 32'hA1A1_0000, "R3");
        expect_out(O_U, 32'hA1A1_0008, "R10");
        wr(8, 32'hF1F1_0008);
        cyc();
        wr(14, 32'hF1F1_000E);
        rd_a_idx_i = 8;
        expect_out(O_A, 32'hF1F1_0008, "R4"); expect_out(O_U, 32'hA1A1_0008, "R4");
        cyc();
        // R5 small banks
        mode_i = M_IRQ; wr(13, 32'h1B1B_000D);
        rd_a_idx_i = 8; rd_b_idx_i = 14;
        expect_out(O_A, 32'hA1A1_0008, "R5"); expect_out(O_B, 32'h0, "R5");
        cyc();
        rd_a_idx_i = 13; usr_rd_idx_i = 13; rd_b_idx_i = 15;
        expect_out(O_A, 32'h1B1B_000D, "R5"); expect_out(O_U, 32'hA1A1_000D, "R5");
        expect_out(O_B, 32'h0000_1000, "R7");
        spsr_wr_en_i = 1'b1; spsr_wr_data_i = 32'h55;
        cyc();
        mode_i = M_SVC; rd_a_idx_i = 13;
        expect_out(O_A, 32'h0, "R5"); expect_out(O_SPSR, 32'h0, "R8");
        wr(14, 32'h5C5C_000E);
        spsr_wr_en_i = 1'b1; spsr_wr_data_i = 32'h66;
        cyc();
        mode_i = M_ABT; rd_a_idx_i = 14;
        expect_out(O_A, 32'h0, "R5"); expect_out(O_SPSR, 32'h0, "R8");
        cyc();
        mode_i = M_UND; rd_a_idx_i = 14; rd_b_idx_i = 13;
        expect_out(O_A, 32'h0, "R5"); expect_out(O_B, 32'h0, "R5");
        cyc();
        mode_i = M_IRQ; expect_out(O_SPSR, 32'h55, "R8");
        cyc();
        mode_i = M_SVC; rd_a_idx_i = 14;
        expect_out(O_SPSR, 32'h66, "R8"); expect_out(O_A, 32'h5C5C_000E, "R5");
        cyc();
        // R6 system mode
        mode_i = M_SYS; rd_a_idx_i = 13; rd_b_idx_i = 8;
        expect_out(O_A, 32'hA1A1_000D, "R6"); expect_out(O_B, 32'hA1A1_0008, "R6");
        cpsr_wr_en_i = 1'b1; cpsr_wr_data_i = 32'h0000_01F3;
        cyc();
        expect_out(O_CPSR, 32'h0000_01F3, "R12"); expect_out(O_SPSR, 32'h0000_01F3, "R9");
        spsr_wr_en_i = 1'b1; spsr_wr_data_i = 32'h77;
        cyc();
        expect_out(O_SPSR, 32'h0000_01F3, "R9");
        cyc();
        mode_i = 5'b00000; rd_a_idx_i = 13; rd_b_idx_i = 14;
        expect_out(O_A, 32'hA1A1_000D, "R6"); expect_out(O_B, 32'h0, "R6");
        expect_out(O_SPSR, 32'h0000_01F3, "R9");
        cyc();
        mode_i = M_IRQ; expect_out(O_SPSR, 32'h55, "R9");
        cyc();
        // R10 user-bank write from supervisor
        mode_i = M_SVC; uwr(13, 32'hEEEE_000D); rd_a_idx_i = 13;
        expect_out(O_A, 32'h0, "R10");
        cyc();
        usr_rd_idx_i = 13;
        expect_out(O_A, 32'h0, "R10"); expect_out(O_U, 32'hEEEE_000D, "R10");
        cyc();
        // R11 write conflicts
        mode_i = M_USR; wr(5, 32'hC1C1_0005); uwr(5, 32'hC2C2_0005);
        cyc();
        rd_a_idx_i = 5; expect_out(O_A, 32'hC1C1_0005, "R11");
        cyc();
        mode_i = M_FIQ; wr(9, 32'hF1F1_0009); uwr(9, 32'hEEEE_0009);
        cyc();
        rd_a_idx_i = 9; usr_rd_idx_i = 9;
        expect_out(O_A, 32'hF1F1_0009, "R11"); expect_out(O_U, 32'hEEEE_0009, "R11");
        expect_out(O_SPSR, 32'h0, "R8");
        cyc();
        mode_i = M_USR; expect_out(O_A, 32'hEEEE_0009, "R4");
        cyc();
        // R1 reset in mid-run
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1; rd_a_idx_i = 5; mode_i = M_IRQ; rd_b_idx_i = 13;
        expect_out(O_A, 32'h0, "R1"); expect_out(O_B, 32'h0, "R1");
        expect_out(O_CPSR, 32'h0, "R1"); expect_out(O_SPSR, 32'h0, "R1");
        cyc();
        cyc();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule